// File: doc/BRIEF.md
# Byte/Word Memory Bus Bridge with I/O Window

This block connects a processor core to a 16-bit-wide memory. The core hands it one read or write at a time, either a single byte or a 16-bit word, at a 16-bit physical byte address. Addresses are not translated, so the whole space is 64 KB. The bridge moves bytes onto the correct half of the data bus in little-endian order. It refuses word accesses at odd addresses, and it sends anything that falls in the top 4 KB of the space to a device register port instead of the RAM.

The core sees three things back. An acknowledge with read data means the access is complete. A one-cycle trap flag means a misaligned word access was refused. A request is only taken while nothing else is in flight, so the core waits for an acknowledge or a trap before it issues the next one. The RAM is synchronous and returns read data in the cycle after its enable. The device port holds its request until the device acknowledges.

Top module: `mem_bus_bridge`

## Requirements
- R1: After reset, rsp_ack, rsp_trap, ram_en and dev_en are all low, and rsp_rdata is zero.
- R2: A word write to an even address below 0xF000 drives ram_en and ram_we for one cycle, starting in the cycle after the request is taken. In that cycle ram_addr is addr[15:1], ram_be is 2'b11 and ram_wdata is the request data unchanged. rsp_ack is high for one cycle in the cycle that follows.
- R3: A byte write sets exactly one strobe bit: ram_be/dev_be is 2'b01 (bits 7:0) when addr[0] is 0 and 2'b10 (bits 15:8) when addr[0] is 1. The request's bits 7:0 are copied onto both byte lanes of the write data.
- R4: Storage is little-endian. For a word read at even address A, bits 7:0 of rsp_rdata hold the byte at A and bits 15:8 hold the byte at A+1.
- R5: A byte read returns the lane chosen by addr[0] (high lane when odd), moved to bits 7:0, with bits 15:8 zero.
- R6: A word access at an odd address is not performed. In the cycle after it is taken, rsp_trap is high for exactly one cycle with rsp_ack low and rsp_rdata zero. Neither ram_en nor dev_en is raised for it.
- R7: An access whose address lies in 0xF000–0xFFFF raises dev_en, never ram_en. dev_addr is addr[11:1], and dev_we, dev_be and dev_wdata are the same as they would be for RAM. Addresses below 0xF000 go to the RAM only.
- R8: A device request holds dev_en and its address, strobes and data steady until dev_ack. rsp_ack rises in the same cycle as dev_ack, and dev_en is low in the next cycle.
- R9: A request raised while an access is in flight is ignored: the pending device request does not change, and no extra RAM cycle or acknowledge follows.
- R10: rsp_ack and rsp_trap are never high together, and rsp_rdata is zero except during the acknowledge of a read.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (bits 7:0 for a byte write) |
| rsp_ack | output | 1 | Access complete |
| rsp_trap | output | 1 | Misaligned word access refused |
| rsp_rdata | output | 16 | Read data, valid with rsp_ack on reads |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 15 | RAM word address |
| ram_be | output | 2 | RAM byte-lane strobes |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, valid the cycle after ram_en |
| dev_en | output | 1 | Device request, held until dev_ack |
| dev_we | output | 1 | Device write enable |
| dev_addr | output | 11 | Device word offset within the window |
| dev_be | output | 2 | Device byte-lane strobes |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data, valid with dev_ack |
| dev_ack | input | 1 | Device completes the request |

## Verification
Word writes followed by byte reads of both halves, and byte writes followed by word reads, separate a correct little-endian lane order from a swapped one. They also show whether the strobes protect the other byte. Odd-address word reads and writes, in both RAM and the device window, separate a trap from a silent access. Accesses at 0xEFFE and 0xF000 sit on either side of the window edge and show where routing switches. Device accesses with latencies of one and several cycles, one of them with a second request raised during the wait, show that the request is held and that requests in flight are ignored.

// File: rtl/bus_bridge_pkg.sv
// Shared definitions for the memory bus bridge.
// Assumes a 16-bit data path made of two byte lanes.
package bus_bridge_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RAM_ISSUE = 2'd1,
        ST_RAM_RESP  = 2'd2,
        ST_DEV_WAIT  = 2'd3
    } bridge_state_t;
endpackage

// File: rtl/bridge_addr_decode.sv
// Address classification. Flags addresses in the device window, which is
// the top 2**IO_BITS bytes of the space, and flags word accesses at odd
// addresses. Purely combinational.
module bridge_addr_decode #(
    parameter int ADDR_W  = 16,
    parameter int IO_BITS = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_byte,
    output logic              in_window,
    output logic              misaligned
);
    localparam int TAG_W = ADDR_W - IO_BITS;

    // Window hit: every address bit above the window offset is one.
    always_comb in_window = &addr[ADDR_W-1 -: TAG_W];

    // Only word accesses need an even address.
    always_comb misaligned = !is_byte && addr[0];
endmodule

// File: rtl/bridge_write_steer.sv
// Write-side lane steering. A word passes straight through with both
// strobes set. A byte is copied to both lanes, and only the lane chosen by
// the low address bit is strobed (little-endian: even = low lane).
module bridge_write_steer
    import bus_bridge_pkg::*;
(
    input  logic                         is_byte,
    input  logic                         odd,
    input  logic [DATA_W-1:0]            wdata_in,
    output logic [DATA_W-1:0]            wdata_out,
    output logic [LANES-1:0]             be
);
    // Builds lane data and strobes for one request.
    always_comb begin
        if (is_byte) begin
            for (int i = 0; i < LANES; i++)
                wdata_out[i*LANE_W +: LANE_W] = wdata_in[LANE_W-1:0];
            be = odd ? 2'b10 : 2'b01;
        end else begin
            wdata_out = wdata_in;
            be        = '1;
        end
    end
endmodule

// File: rtl/bridge_read_steer.sv
// Read-side lane steering. A word returns unchanged. A byte read takes the
// lane chosen by the low address bit, moves it to bits 7:0 and clears the
// upper lane.
module bridge_read_steer
    import bus_bridge_pkg::*;
(
    input  logic              is_byte,
    input  logic              odd,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] data_out
);
    // Picks and right-aligns the addressed byte for byte reads.
    always_comb begin
        if (is_byte) begin
            data_out = '0;
            data_out[LANE_W-1:0] = odd ? word_in[DATA_W-1 -: LANE_W]
                                       : word_in[LANE_W-1:0];
        end else begin
            data_out = word_in;
        end
    end
endmodule

// File: rtl/mem_bus_bridge.sv
// Core-to-memory bridge. Takes one byte or word request at a time. It traps
// misaligned word accesses and sends the top window of the address space to
// the device port, everything else to a synchronous RAM.
// Assumes: the RAM returns read data the cycle after ram_en; the device
// holds dev_rdata valid while dev_ack is high; requests are ignored while
// one is in flight.
module mem_bus_bridge
    import bus_bridge_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int IO_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              rsp_ack,
    output logic              rsp_trap,
    output logic [15:0]       rsp_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-2:0] ram_addr,
    output logic [1:0]        ram_be,
    output logic [15:0]       ram_wdata,
    input  logic [15:0]       ram_rdata,
    output logic              dev_en,
    output logic              dev_we,
    output logic [IO_BITS-2:0] dev_addr,
    output logic [1:0]        dev_be,
    output logic [15:0]       dev_wdata,
    input  logic [15:0]       dev_rdata,
    input  logic              dev_ack
);
    localparam int WORD_AW = ADDR_W - 1;
    localparam int DEV_AW  = IO_BITS - 1;

    bridge_state_t      state;
    logic               accept;
    logic               hit_io;
    logic               bad_align;
    logic [DATA_W-1:0]  lane_wdata;
    logic [LANES-1:0]   lane_be;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  rd_steered;

    logic               cur_we;
    logic               cur_byte;
    logic               cur_odd;
    logic [LANES-1:0]   cur_be;
    logic [DATA_W-1:0]  cur_wd;
    logic [WORD_AW-1:0] cur_waddr;
    logic               trap_q;

    // A request is taken only when nothing is in flight.
    always_comb accept = (state == ST_IDLE) && req_valid;

    bridge_addr_decode #(.ADDR_W(ADDR_W), .IO_BITS(IO_BITS)) u_dec (
        .addr       (req_addr),
        .is_byte    (req_byte),
        .in_window  (hit_io),
        .misaligned (bad_align)
    );

    bridge_write_steer u_wst (
        .is_byte   (req_byte),
        .odd       (req_addr[0]),
        .wdata_in  (req_wdata),
        .wdata_out (lane_wdata),
        .be        (lane_be)
    );

    // Sequencer: routes a taken request and tracks it until it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            trap_q    <= 1'b0;
            cur_we    <= 1'b0;
            cur_byte  <= 1'b0;
            cur_odd   <= 1'b0;
            cur_be    <= '0;
            cur_wd    <= '0;
            cur_waddr <= '0;
        end else begin
            trap_q <= accept && bad_align;
            unique case (state)
                ST_IDLE: begin
                    if (accept && !bad_align) begin
                        state     <= hit_io ? ST_DEV_WAIT : ST_RAM_ISSUE;
                        cur_we    <= req_write;
                        cur_byte  <= req_byte;
                        cur_odd   <= req_addr[0];
                        cur_be    <= lane_be;
                        cur_wd    <= lane_wdata;
                        cur_waddr <= req_addr[ADDR_W-1:1];
                    end
                end
                ST_RAM_ISSUE: state <= ST_RAM_RESP;
                ST_RAM_RESP:  state <= ST_IDLE;
                ST_DEV_WAIT:  if (dev_ack) state <= ST_IDLE;
                default:      state <= ST_IDLE;
            endcase
        end
    end

    // RAM port: one enable cycle per access.
    always_comb begin
        ram_en    = (state == ST_RAM_ISSUE);
        ram_we    = ram_en && cur_we;
        ram_addr  = cur_waddr;
        ram_be    = cur_be;
        ram_wdata = cur_wd;
    end

    // Device port: held while waiting for the device.
    always_comb begin
        dev_en    = (state == ST_DEV_WAIT);
        dev_we    = dev_en && cur_we;
        dev_addr  = cur_waddr[DEV_AW-1:0];
        dev_be    = cur_be;
        dev_wdata = cur_wd;
    end

    // Read source follows the path the access took.
    always_comb rd_word = (state == ST_DEV_WAIT) ? dev_rdata : ram_rdata;

    bridge_read_steer u_rst (
        .is_byte  (cur_byte),
        .odd      (cur_odd),
        .word_in  (rd_word),
        .data_out (rd_steered)
    );

    // Core response: acknowledge, trap and read data.
    always_comb begin
        rsp_ack   = (state == ST_RAM_RESP) || ((state == ST_DEV_WAIT) && dev_ack);
        rsp_trap  = trap_q;
        rsp_rdata = (rsp_ack && !cur_we) ? rd_steered : '0;
    end

    // R10: acknowledge and trap never coincide.
    p_ack_trap_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ack && rsp_trap));

    // R6: the trap is a single-cycle pulse.
    p_trap_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |=> !rsp_trap);

    // R6: a refused access touches neither memory port.
    p_trap_no_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (!ram_en && !dev_en));

    // R2: a RAM cycle is acknowledged in the following cycle.
    p_ram_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |=> (rsp_ack && !ram_en));

    // R7: only one memory port is active at a time.
    p_port_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_en && dev_en));

    // R8: a waiting device request stays steady.
    p_dev_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_en && !dev_ack) |=> (dev_en && $stable(dev_addr) && $stable(dev_be)
                                  && $stable(dev_wdata) && $stable(dev_we)));

    // R3: a write always strobes at least one lane.
    p_strobe_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_be != 2'b00));
endmodule

// File: tb/sim_mem_bus_bridge.sv
// Bench for mem_bus_bridge: a behavioural byte-array model predicts every
// cycle of each access, and a behavioural RAM serves the RAM port.
module sim_mem_bus_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        rsp_ack, rsp_trap;
    logic [15:0] rsp_rdata;
    logic        ram_en, ram_we;
    logic [14:0] ram_addr;
    logic [1:0]  ram_be;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;
    logic        dev_en, dev_we;
    logic [10:0] dev_addr;
    logic [1:0]  dev_be;
    logic [15:0] dev_wdata;
    logic [15:0] dev_rdata = '0;
    logic        dev_ack = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] ram_store [int];
    logic [7:0]  model [int];

    always #2 clk = ~clk;

    mem_bus_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_byte(req_byte),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_ack(rsp_ack), .rsp_trap(rsp_trap), .rsp_rdata(rsp_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .dev_en(dev_en), .dev_we(dev_we), .dev_addr(dev_addr), .dev_be(dev_be),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ack(dev_ack)
    );

    // Behavioural synchronous RAM with byte strobes.
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                logic [15:0] w;
                w = ram_store.exists(int'(ram_addr)) ? ram_store[int'(ram_addr)] : 16'h0;
                if (ram_be[0]) w[7:0]  = ram_wdata[7:0];
                if (ram_be[1]) w[15:8] = ram_wdata[15:8];
                ram_store[int'(ram_addr)] = w;
            end else begin
                ram_rdata <= ram_store.exists(int'(ram_addr)) ? ram_store[int'(ram_addr)] : 16'h0;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(int a);
        return model.exists(a) ? model[a] : 8'h00;
    endfunction

    function automatic logic [15:0] dev_pattern(logic [15:0] a);
        return {a[7:0] ^ 8'h5A, a[8:1]};
    endfunction

    // One access, checked on every cycle from issue to completion.
    task automatic access(bit wr, bit by, logic [15:0] a, logic [15:0] wd,
                          int lat, bit poke);
        logic [15:0] exp_wd, exp_rd, word;
        logic [1:0]  exp_be;
        bit io, bad;
        io  = (a >= 16'hF000);
        bad = !by && a[0];
        exp_wd = by ? {wd[7:0], wd[7:0]} : wd;
        exp_be = by ? (a[0] ? 2'b10 : 2'b01) : 2'b11;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_byte = by; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            chk("R6 trap", rsp_trap, 1);
            chk("R6 no ack", rsp_ack, 0);
            chk("R6 rdata zero", rsp_rdata, 0);
            chk("R6 no bus", {ram_en, dev_en}, 0);
            @(negedge clk);
            chk("R6 trap one cycle", rsp_trap, 0);
            chk("R6 still no bus", {ram_en, dev_en, rsp_ack}, 0);
            return;
        end
        if (io) begin
            for (int i = 0; i < lat; i++) begin
                if (poke && i == 0) begin
                    req_valid = 1'b1; req_write = 1'b1; req_byte = 1'b0;
                    req_addr = 16'h0040; req_wdata = 16'hDEAD;
                end
                chk("R7 dev_en", dev_en, 1);
                chk("R7 no ram", ram_en, 0);
                chk("R7 dev_addr", dev_addr, a[11:1]);
                chk("R3 dev_be", dev_be, exp_be);
                chk("R7 dev_we", dev_we, wr);
                if (wr) chk("R3 dev_wdata", dev_wdata, exp_wd);
                chk("R8 no early ack", rsp_ack, 0);
                if (i + 1 < lat) begin
                    @(negedge clk);
                    req_valid = 1'b0;
                end
            end
            req_valid = 1'b0;
            word = dev_pattern(a);
            dev_rdata = word; dev_ack = 1'b1;
            #1;
            exp_rd = wr ? 16'h0 : (by ? {8'h00, a[0] ? word[15:8] : word[7:0]} : word);
            chk("R8 ack with dev_ack", rsp_ack, 1);
            chk(by ? "R5 dev byte read" : "R4 dev word read", rsp_rdata, exp_rd);
            @(negedge clk);
            dev_ack = 1'b0; dev_rdata = '0;
            chk("R8 dev_en drops", dev_en, 0);
            chk("R9 no extra ack", {rsp_ack, ram_en}, 0);
            return;
        end
        chk("R7 ram_en", ram_en, 1);
        chk("R7 no dev", dev_en, 0);
        chk("R2 ram_we", ram_we, wr);
        chk("R2 ram_addr", ram_addr, a[15:1]);
        chk("R3 ram_be", ram_be, exp_be);
        if (wr) chk("R3 ram_wdata", ram_wdata, exp_wd);
        chk("R2 no early ack", rsp_ack, 0);
        if (wr) begin
            if (by) model[int'(a)] = wd[7:0];
            else begin model[int'(a)] = wd[7:0]; model[int'(a) + 1] = wd[15:8]; end
            exp_rd = 16'h0;
        end else if (by) exp_rd = {8'h00, mbyte(int'(a))};
        else exp_rd = {mbyte(int'(a) + 1), mbyte(int'(a))};
        @(negedge clk);
        chk("R2 ack", rsp_ack, 1);
        chk("R2 ram_en one cycle", ram_en, 0);
        chk(wr ? "R10 rdata zero on write" : (by ? "R5 byte read" : "R4 word read"),
            rsp_rdata, exp_rd);
        @(negedge clk);
        chk("R10 ack drops", rsp_ack, 0);
        chk("R10 rdata idle zero", rsp_rdata, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 outputs idle", {rsp_ack, rsp_trap, ram_en, dev_en}, 0);
        chk("R1 rdata zero", rsp_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {rsp_ack, rsp_trap, ram_en, dev_en}, 0);

        // R2/R4/R5: word write, then word and byte reads.
        access(1, 0, 16'h0100, 16'hBEEF, 0, 0);
        access(0, 0, 16'h0100, 16'h0, 0, 0);
        access(0, 1, 16'h0100, 16'h0, 0, 0);
        access(0, 1, 16'h0101, 16'h0, 0, 0);
        // R3: byte writes into each lane, then whole word read.
        access(1, 1, 16'h0200, 16'h0012, 0, 0);
        access(1, 1, 16'h0203, 16'h0077, 0, 0);
        access(1, 1, 16'h0201, 16'hFF34, 0, 0);
        access(0, 0, 16'h0200, 16'h0, 0, 0);
        access(0, 0, 16'h0202, 16'h0, 0, 0);
        access(1, 1, 16'h0100, 16'h00AA, 0, 0);
        access(0, 0, 16'h0100, 16'h0, 0, 0);
        // R6: misaligned words, RAM and device window.
        access(0, 0, 16'h0101, 16'h0, 0, 0);
        access(1, 0, 16'h0301, 16'h1234, 0, 0);
        access(1, 0, 16'hF003, 16'h1234, 0, 0);
        access(0, 0, 16'h0300, 16'h0, 0, 0);
        // R7: window edge on both sides.
        access(1, 0, 16'hEFFE, 16'hC0DE, 0, 0);
        access(0, 0, 16'hEFFE, 16'h0, 0, 0);
        access(0, 0, 16'hF000, 16'h0, 1, 0);
        access(1, 1, 16'hF7FF, 16'h00A5, 2, 0);
        access(0, 1, 16'hF123, 16'h0, 3, 0);
        access(1, 0, 16'hFFFE, 16'h4321, 1, 0);
        // R8/R9: long device wait with an intruding request.
        access(0, 0, 16'hF456, 16'h0, 5, 1);
        access(0, 0, 16'h0040, 16'h0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule